// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is the second-operand shifter of a 32-bit RISC datapath. Each cycle it takes an operand, the current carry flag and already-extracted shift fields, then computes the shifted operand and the carry the shift produces. The shift fields are a 3-bit kind code, a 5-bit immediate amount, an 8-bit amount taken from a register, and a select for the even-rotate mode used by 8-bit immediates.

The kind code packs the direction and the amount source together:

- Bit 0 picks the amount source: 0 for the immediate field, 1 for the register amount.
- Bits 2:1 pick the operation: 00 for logical left, 01 for logical right, 10 for arithmetic right, 11 for rotate right.

Several amounts carry special meaning:

- Immediate zero means different things per operation.
- Register amounts reach 255, so amounts of exactly 32 and above 32 have defined results and defined carries.
- An immediate rotate of zero becomes a 33-bit rotate by one through the carry flag.

Both outputs are registered on the rising clock edge and clear on an active-low asynchronous reset. A global enable freezes both outputs. A separate carry-update enable freezes only the carry output while the data output keeps updating.

Top module: `opshift_unit`

## Requirements
- R1: While rst_n is low, shift_q and carry_q are 0.
- R2: Immediate left shift (kind 000). An amount of 0 returns the operand unchanged with carry equal to carry_in. An amount n from 1 to 31 gives operand<<n with carry equal to operand bit 32-n.
- R3: Immediate logical right (kind 010) and immediate arithmetic right (kind 100) with an amount of 0 act as a shift by 32. Logical right gives 0. Arithmetic right gives every bit equal to operand bit 31. The carry is operand bit 31 in both cases. Nonzero n gives the usual shift with carry equal to operand bit n-1.
- R4: Immediate rotate right (kind 110) by n from 1 to 31 gives carry equal to operand bit n-1. An amount of 0 gives {carry_in, operand[31:1]} with carry equal to operand bit 0.
- R5: Any register-amount kind (kind bit 0 = 1) whose reg_amt is 0 returns the operand unchanged with carry equal to carry_in.
- R6: Register left shift (001) and register logical right shift (011) by exactly 32 give 0. The carry is operand bit 0 for the left shift and operand bit 31 for the right shift. Amounts above 32 give 0 with carry 0.
- R7: Register arithmetic right shift (101) by 32 or more gives every bit equal to operand bit 31, with carry equal to operand bit 31.
- R8: Register rotate right (111) uses reg_amt modulo 32. A nonzero multiple of 32 leaves the operand unchanged with carry equal to operand bit 31. Any other amount gives carry equal to the last bit rotated out.
- R9: When rot_imm_sel is 1, kind is ignored and the operand is rotated right by 2*imm_amt[4:1]. A zero field gives carry equal to carry_in. Otherwise the carry equals bit 31 of the rotated result.
- R10: When shift_en is 0, shift_q and carry_q keep their values at the next edge.
- R11: When shift_en is 1 and carry_upd_en is 0, shift_q updates and carry_q keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Load enable for both outputs |
| carry_upd_en | input | 1 | Load enable for the carry output |
| operand_in | input | 32 | Operand to shift |
| carry_in | input | 1 | Current carry flag |
| kind | input | 3 | Operation and amount-source code |
| imm_amt | input | 5 | Immediate shift amount; bits 4:1 are the rotate field |
| reg_amt | input | 8 | Register shift amount, 0 to 255 |
| rot_imm_sel | input | 1 | Selects even rotate of an immediate |
| shift_q | output | 32 | Registered shifted operand |
| carry_q | output | 1 | Registered shifter carry-out |

## Verification
Two things can act in the same cycle. A data update can coincide with a frozen carry, and the rotate-immediate select can coincide with a kind code that would otherwise name a different shift. The bench provokes the first by holding carry_upd_en low while it drives shifts whose carry would differ from the held value. It then judges that shift_q takes the new result and carry_q keeps the old one. It provokes the second by driving each of the eight kind codes together with rot_imm_sel, and judges both outputs against an independent bit-by-bit rotate model.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  // Normalised operation after amount decoding
  typedef enum logic [2:0] {
    SOP_PASS = 3'd0,
    SOP_LSL  = 3'd1,
    SOP_LSR  = 3'd2,
    SOP_ASR  = 3'd3,
    SOP_ROR  = 3'd4,
    SOP_RRX  = 3'd5
  } sop_e;

  // Operation family held in kind[2:1]
  localparam logic [1:0] FAM_LSL = 2'b00;
  localparam logic [1:0] FAM_LSR = 2'b01;
  localparam logic [1:0] FAM_ASR = 2'b10;
  localparam logic [1:0] FAM_ROR = 2'b11;
endpackage

// File: rtl/opshift_decode.sv
module opshift_decode
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int RAMT_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic [2:0]        kind,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [RAMT_W-1:0] reg_amt,
  input  logic              rot_imm_sel,
  output sop_e              sop,
  output logic [AMT_W-1:0]  amt,
  output logic              ev_imm_as_full,
  output logic              ev_rrx,
  output logic              ev_reg_zero
);
  logic [1:0] fam;
  logic       by_reg;
  logic [AMT_W-1:0] rot_amt;

  assign fam     = kind[2:1];
  assign by_reg  = kind[0];
  assign rot_amt = AMT_W'({imm_amt[IMM_W-1:1], 1'b0});

  function automatic sop_e fam_to_sop(input logic [1:0] f);
    case (f)
      FAM_LSL: return SOP_LSL;
      FAM_LSR: return SOP_LSR;
      FAM_ASR: return SOP_ASR;
      default: return SOP_ROR;
    endcase
  endfunction

  always_comb begin
    sop            = SOP_PASS;
    amt            = '0;
    ev_imm_as_full = 1'b0;
    ev_rrx         = 1'b0;
    ev_reg_zero    = 1'b0;
    if (rot_imm_sel) begin
      amt = rot_amt;
      sop = (rot_amt == '0) ? SOP_PASS : SOP_ROR;
    end else if (by_reg) begin
      amt         = AMT_W'(reg_amt);
      ev_reg_zero = (reg_amt == '0);
      sop         = ev_reg_zero ? SOP_PASS : fam_to_sop(fam);
    end else if (imm_amt != '0) begin
      amt = AMT_W'(imm_amt);
      sop = fam_to_sop(fam);
    end else begin
      case (fam)
        FAM_LSL: sop = SOP_PASS;
        FAM_LSR: begin sop = SOP_LSR; amt = AMT_W'(DATA_W); ev_imm_as_full = 1'b1; end
        FAM_ASR: begin sop = SOP_ASR; amt = AMT_W'(DATA_W); ev_imm_as_full = 1'b1; end
        default: begin sop = SOP_RRX; ev_rrx = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  sop_e              sop,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] operand,
  input  logic              cin,
  output logic [DATA_W-1:0] data,
  output logic              carry,
  output logic              ev_wide_amt
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] MASK = AMT_W'(DATA_W - 1);
  localparam logic [AMT_W-1:0] ONE  = AMT_W'(1);

  // Each function returns {carry, data}
  function automatic logic [DATA_W:0] f_lsl(input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] n);
    logic [DATA_W-1:0] t;
    if (n < FULL) begin
      t = v >> (FULL - n);
      return {t[0], v << n};
    end
    if (n == FULL) return {v[0], {DATA_W{1'b0}}};
    return '0;
  endfunction

  function automatic logic [DATA_W:0] f_lsr(input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] n);
    logic [DATA_W-1:0] t;
    if (n < FULL) begin
      t = v >> (n - ONE);
      return {t[0], v >> n};
    end
    if (n == FULL) return {v[DATA_W-1], {DATA_W{1'b0}}};
    return '0;
  endfunction

  function automatic logic [DATA_W:0] f_asr(input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] n);
    logic [DATA_W-1:0] t;
    logic [DATA_W-1:0] s;
    if (n < FULL) begin
      t = v >> (n - ONE);
      s = $signed(v) >>> n;
      return {t[0], s};
    end
    return {v[DATA_W-1], {DATA_W{v[DATA_W-1]}}};
  endfunction

  function automatic logic [DATA_W:0] f_ror(input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] n);
    logic [AMT_W-1:0]  r;
    logic [DATA_W-1:0] t;
    r = n & MASK;
    if (r == '0) return {v[DATA_W-1], v};
    t = v >> (r - ONE);
    return {t[0], (v >> r) | (v << (FULL - r))};
  endfunction

  function automatic logic [DATA_W:0] f_rrx(input logic [DATA_W-1:0] v, input logic c);
    return {v[0], c, v[DATA_W-1:1]};
  endfunction

  logic [DATA_W:0] res;

  always_comb begin
    case (sop)
      SOP_LSL: res = f_lsl(operand, amt);
      SOP_LSR: res = f_lsr(operand, amt);
      SOP_ASR: res = f_asr(operand, amt);
      SOP_ROR: res = f_ror(operand, amt);
      SOP_RRX: res = f_rrx(operand, cin);
      default: res = {cin, operand};
    endcase
  end

  assign data        = res[DATA_W-1:0];
  assign carry       = res[DATA_W];
  assign ev_wide_amt = (sop != SOP_PASS) && (sop != SOP_RRX) && (amt >= FULL);
endmodule

// File: rtl/opshift_outreg.sv
module opshift_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              carry_load,
  input  logic [DATA_W-1:0] d,
  input  logic              c,
  output logic [DATA_W-1:0] q,
  output logic              cq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      cq <= 1'b0;
    end else if (load) begin
      q <= d;
      if (carry_load) cq <= c;
    end
  end
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int RAMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              carry_upd_en,
  input  logic [DATA_W-1:0] operand_in,
  input  logic              carry_in,
  input  logic [2:0]        kind,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [RAMT_W-1:0] reg_amt,
  input  logic              rot_imm_sel,
  output logic [DATA_W-1:0] shift_q,
  output logic              carry_q
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int AMT_W = (RAMT_W > LOG_W + 1) ? RAMT_W : LOG_W + 1;

  sop_e              dec_sop;
  logic [AMT_W-1:0]  dec_amt;
  logic              ev_imm_as_full;
  logic              ev_rrx;
  logic              ev_reg_zero;
  logic              ev_wide_amt;
  logic [DATA_W-1:0] core_data;
  logic              core_carry;

  opshift_decode #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .RAMT_W(RAMT_W), .AMT_W(AMT_W)
  ) u_decode (
    .kind(kind), .imm_amt(imm_amt), .reg_amt(reg_amt), .rot_imm_sel(rot_imm_sel),
    .sop(dec_sop), .amt(dec_amt),
    .ev_imm_as_full(ev_imm_as_full), .ev_rrx(ev_rrx), .ev_reg_zero(ev_reg_zero)
  );

  opshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .sop(dec_sop), .amt(dec_amt), .operand(operand_in), .cin(carry_in),
    .data(core_data), .carry(core_carry), .ev_wide_amt(ev_wide_amt)
  );

  opshift_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .load(shift_en), .carry_load(carry_upd_en),
    .d(core_data), .c(core_carry), .q(shift_q), .cq(carry_q)
  );
endmodule

// File: rtl/opshift_chk.sv
module opshift_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int RAMT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              carry_upd_en,
  input logic [DATA_W-1:0] operand_in,
  input logic              carry_in,
  input logic [2:0]        kind,
  input logic [IMM_W-1:0]  imm_amt,
  input logic [RAMT_W-1:0] reg_amt,
  input logic              rot_imm_sel,
  input logic [DATA_W-1:0] shift_q,
  input logic              carry_q,
  input logic              ev_rrx,
  input logic              ev_reg_zero
);
  localparam logic [RAMT_W-1:0] FULL_R = RAMT_W'(DATA_W);

  always_comb begin
    if (!rst_n) AST_RESET_CLEAR: assert (shift_q == '0 && carry_q == 1'b0); // R1
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shift_q) && $stable(carry_q)); // R10

  AST_CARRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !carry_upd_en) |=> $stable(carry_q)); // R11

  AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && ev_reg_zero) |=> shift_q == $past(operand_in) &&
      (!$past(carry_upd_en) || carry_q == $past(carry_in))); // R5

  AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && ev_rrx) |=> shift_q == {$past(carry_in), $past(operand_in[DATA_W-1:1])}); // R4

  AST_LSL_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !rot_imm_sel && kind == 3'b001 && reg_amt > FULL_R) |=>
      shift_q == '0 && (!$past(carry_upd_en) || carry_q == 1'b0)); // R6

  AST_ASR_IMM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !rot_imm_sel && kind == 3'b100 && imm_amt == '0) |=>
      shift_q == {DATA_W{$past(operand_in[DATA_W-1])}}); // R3

  AST_ROT_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && rot_imm_sel && imm_amt[IMM_W-1:1] == '0) |=>
      shift_q == $past(operand_in) && (!$past(carry_upd_en) || carry_q == $past(carry_in))); // R9
endmodule

bind opshift_unit opshift_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .RAMT_W(RAMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .carry_upd_en(carry_upd_en),
  .operand_in(operand_in), .carry_in(carry_in), .kind(kind), .imm_amt(imm_amt),
  .reg_amt(reg_amt), .rot_imm_sel(rot_imm_sel), .shift_q(shift_q), .carry_q(carry_q),
  .ev_rrx(ev_rrx), .ev_reg_zero(ev_reg_zero)
);

// File: tb/opshift_unit_tb.sv
module opshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        carry_upd_en = 1'b0;
  logic [31:0] operand_in = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  kind = '0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        rot_imm_sel = 1'b0;
  logic [31:0] shift_q;
  logic        carry_q;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_d = '0;
  logic        exp_c = 1'b0;

  always #10 clk = ~clk;

  opshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .carry_upd_en(carry_upd_en),
    .operand_in(operand_in), .carry_in(carry_in), .kind(kind), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .rot_imm_sel(rot_imm_sel), .shift_q(shift_q), .carry_q(carry_q)
  );

  // Bit-serial reference: steps of one position, carry = last bit moved out
  function automatic logic [32:0] ref_model(input logic [2:0] k, input logic [4:0] im,
      input logic [7:0] ra, input logic rs, input logic [31:0] op, input logic ci);
    logic [31:0] v;
    logic        c;
    int          steps;
    int          fam;
    v = op; c = ci;
    if (rs) begin
      fam = 3; steps = 2 * int'(im[4:1]);
    end else begin
      fam = int'(k[2:1]);
      steps = k[0] ? int'(ra) : int'(im);
      if (!k[0] && im == 0) begin
        if (fam == 1 || fam == 2) steps = 32;
        if (fam == 3) return {op[0], ci, op[31:1]};
      end
    end
    for (int i = 0; i < steps; i++) begin
      case (fam)
        0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic check(input string req, input logic [31:0] got_d, input logic got_c);
    total++;
    if (got_d !== exp_d) begin
      bad++;
      $display("FAIL %s data actual=%h expected=%h", req, got_d, exp_d);
    end
    total++;
    if (got_c !== exp_c) begin
      bad++;
      $display("FAIL %s carry actual=%b expected=%b", req, got_c, exp_c);
    end
  endtask

  // Drive one cycle at a falling edge, check after the next rising edge
  task automatic apply(input string req, input logic [2:0] k, input logic [4:0] im,
      input logic [7:0] ra, input logic rs, input logic [31:0] op, input logic ci,
      input logic en, input logic cu);
    logic [32:0] r;
    @(negedge clk);
    kind = k; imm_amt = im; reg_amt = ra; rot_imm_sel = rs;
    operand_in = op; carry_in = ci; shift_en = en; carry_upd_en = cu;
    r = ref_model(k, im, ra, rs, op, ci);
    if (en) begin
      exp_d = r[31:0];
      if (cu) exp_c = r[32];
    end
    @(negedge clk);
    check(req, shift_q, carry_q);
  endtask

  task automatic t_reset;
    exp_d = '0; exp_c = 1'b0;
    #5 check("R1", shift_q, carry_q);
    @(negedge clk); check("R1", shift_q, carry_q);
    rst_n = 1'b1;
  endtask

  task automatic t_imm_lsl;
    apply("R2", 3'b000, 5'd0, 8'd0, 0, 32'h5A5A_A5A5, 1, 1, 1);
    apply("R2", 3'b000, 5'd1, 8'd0, 0, 32'h8000_0001, 0, 1, 1);
    apply("R2", 3'b000, 5'd31, 8'd0, 0, 32'h0000_0003, 0, 1, 1);
    apply("R2", 3'b000, 5'd4, 8'd0, 0, 32'h1234_5678, 1, 1, 1);
  endtask

  task automatic t_imm_right;
    apply("R3", 3'b010, 5'd0, 8'd0, 0, 32'h8000_0000, 0, 1, 1);
    apply("R3", 3'b100, 5'd0, 8'd0, 0, 32'h8000_1234, 0, 1, 1);
    apply("R3", 3'b100, 5'd0, 8'd0, 0, 32'h7FFF_FFFF, 1, 1, 1);
    apply("R3", 3'b010, 5'd3, 8'd0, 0, 32'hF000_0004, 0, 1, 1);
    apply("R3", 3'b100, 5'd7, 8'd0, 0, 32'h8000_00C0, 0, 1, 1);
  endtask

  task automatic t_imm_ror;
    apply("R4", 3'b110, 5'd8, 8'd0, 0, 32'h1234_5680, 0, 1, 1);
    apply("R4", 3'b110, 5'd0, 8'd0, 0, 32'h0000_0003, 1, 1, 1);
    apply("R4", 3'b110, 5'd0, 8'd0, 0, 32'hFFFF_FFFE, 0, 1, 1);
  endtask

  task automatic t_reg_zero;
    for (int k = 1; k < 8; k += 2)
      apply("R5", 3'(k), 5'd9, 8'd0, 0, 32'hC3C3_0F0F, k[1], 1, 1);
  endtask

  task automatic t_reg_edges;
    apply("R6", 3'b001, 5'd0, 8'd32, 0, 32'h0000_0001, 0, 1, 1);
    apply("R6", 3'b001, 5'd0, 8'd33, 0, 32'hFFFF_FFFF, 1, 1, 1);
    apply("R6", 3'b011, 5'd0, 8'd32, 0, 32'h8000_0000, 0, 1, 1);
    apply("R6", 3'b011, 5'd0, 8'd200, 0, 32'hFFFF_FFFF, 1, 1, 1);
    apply("R6", 3'b001, 5'd0, 8'd31, 0, 32'h0000_0003, 0, 1, 1);
  endtask

  task automatic t_reg_asr;
    apply("R7", 3'b101, 5'd0, 8'd32, 0, 32'h8000_0000, 0, 1, 1);
    apply("R7", 3'b101, 5'd0, 8'd255, 0, 32'h4000_0001, 1, 1, 1);
    apply("R7", 3'b101, 5'd0, 8'd12, 0, 32'hF00F_F000, 0, 1, 1);
  endtask

  task automatic t_reg_ror;
    apply("R8", 3'b111, 5'd0, 8'd64, 0, 32'h8765_4321, 0, 1, 1);
    apply("R8", 3'b111, 5'd0, 8'd36, 0, 32'h0000_000F, 0, 1, 1);
    apply("R8", 3'b111, 5'd0, 8'd1, 0, 32'h0000_0002, 1, 1, 1);
  endtask

  task automatic t_rot_imm;
    apply("R9", 3'b000, {4'hE, 1'b0}, 8'd0, 1, 32'h0000_003F, 0, 1, 1);
    total++;
    if (shift_q !== 32'h0000_03F0) begin
      bad++; $display("FAIL R9 data actual=%h expected=%h", shift_q, 32'h0000_03F0);
    end
    apply("R9", 3'b011, {4'hF, 1'b1}, 8'd5, 1, 32'h0000_00FC, 1, 1, 1);
    apply("R9", 3'b101, {4'h1, 1'b0}, 8'd0, 1, 32'h0000_0002, 0, 1, 1);
    apply("R9", 3'b110, 5'd1, 8'd0, 1, 32'hABCD_EF01, 1, 1, 1);
    for (int k = 0; k < 8; k++)
      apply("R9", 3'(k), {4'h4, 1'b0}, 8'd40, 1, 32'h00FF_0080, k[0], 1, 1);
  endtask

  task automatic t_enable_hold;
    apply("R10", 3'b000, 5'd2, 8'd0, 0, 32'h0000_0001, 1, 1, 1);
    apply("R10", 3'b010, 5'd1, 8'd0, 0, 32'hFFFF_FFFF, 0, 0, 1);
    apply("R10", 3'b111, 5'd0, 8'd3, 0, 32'h0000_0007, 1, 0, 0);
  endtask

  task automatic t_carry_hold;
    apply("R11", 3'b010, 5'd1, 8'd0, 0, 32'h0000_0001, 0, 1, 1);
    apply("R11", 3'b010, 5'd1, 8'd0, 0, 32'h0000_0004, 0, 1, 0);
    apply("R11", 3'b001, 5'd0, 8'd1, 0, 32'h0000_0000, 0, 1, 0);
    apply("R11", 3'b110, 5'd0, 8'd0, 0, 32'h0000_0000, 1, 1, 0);
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply("R2-sweep", lfsr[2:0], lfsr[7:3], lfsr[15:8], lfsr[16] & lfsr[17],
            lfsr ^ {lfsr[15:0], lfsr[31:16]}, lfsr[20], 1, 1);
    end
  endtask

  initial begin
    t_reset;
    t_imm_lsl;
    t_imm_right;
    t_imm_ror;
    t_reg_zero;
    t_reg_edges;
    t_reg_asr;
    t_reg_ror;
    t_rot_imm;
    t_enable_hold;
    t_carry_hold;
    t_sweep;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule